// File: doc/BRIEF.md
# Byte-Banked Edge-Capturing Interrupt Aggregator

This block gathers 24 interrupt request lines into three byte-wide banks and drives a single combined interrupt toward a host pin that detects rising edges. Every line passes through a synchronizer. All lines but one are edge-captured: a 0-to-1 transition on an enabled line sets a pending bit. That bit stays set until the host reads the status byte of its bank. No separate acknowledge register exists. One designated line is level-sensitive. Its status bit shows the live request and a read does not clear it.

The host reaches the block through a small byte-wide register port. A 3-bit address selects a status byte or a mask byte for each bank. Reads return data on the cycle after the read strobe. A mask bit of 1 enables its line. An edge seen while its line is disabled is dropped for good.

The combined output is registered. It is the OR of all enabled status bits. After any status read it is held low for one cycle, so pending work that remains produces a fresh rising edge at the host.

Top module: `irq_edge_aggregator`

## Requirements
- R1: After reset every mask byte, every status byte, `reg_rdata` and `irq_out` read as zero.
- R2: Address 2b selects the status byte of bank b and address 2b+1 selects the mask byte of bank b (bank 0 = sources 0..7, bank 1 = 8..15, bank 2 = 16..23). Mask bytes read back what was written. Addresses 6 and 7 read zero, and writes to them change nothing.
- R3: A 0-to-1 transition on an enabled edge-type source sets status bit (source mod 8) of bank (source div 8). The bit is visible by the fourth clock edge after the input change.
- R4: A status read returns the byte on the cycle after the strobe. The same read clears the edge-captured bits of that bank only.
- R5: A rising edge that arrives while its mask bit is 0 is not captured. Setting the mask bit later, while the line stays high, does not capture it either.
- R6: The level-type source (default source 12, bank 1 bit 4) has a status bit that follows the synchronized live level, whatever its mask bit, and a status read does not clear it.
- R7: `irq_out` is the registered OR of status AND mask over all 24 bits. Clearing a mask bit hides a pending bit without discarding it.
- R8: `irq_out` is low in the cycle after any status read. If enabled status bits remain, it rises again on the following cycle.
- R9: If an edge is detected in the same cycle as the status read that clears its bank, the bit stays pending. The read data still shows the value from before the edge.
- R10: Writes to a status address have no effect on status.
- R11: A line held high produces exactly one capture. After a clearing read it stays clear until a new 0-to-1 transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 24 | Interrupt request lines, asynchronous |
| reg_addr | input | 3 | Register byte address |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
Corrupted pending state shows at the ports in two ways. The next status read returns the wrong byte, and `irq_out` takes a wrong level within one cycle. A pending bit that fails to clear is caught by a second read of the same bank. A bit cleared in the wrong bank is caught by reading a neighbouring bank that should still be pending. Faults in edge detection, such as recapture of a held line or capture while disabled, are exposed by reading status four cycles after the input changes and by the low pulse and re-rise of `irq_out` around each read.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Low address bit selects register kind inside a bank
  typedef enum logic {
    KIND_STATUS = 1'b0,
    KIND_MASK   = 1'b1
  } reg_kind_e;

endpackage

// File: rtl/irqagg_sync.sv
// Multi-stage synchronizer plus a registered copy for rise detection.
module irqagg_sync #(
  parameter int W           = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);

  logic [SYNC_STAGES-1:0][W-1:0] stg_q, stg_d;
  logic [W-1:0]                  prev_q, prev_d;

  always_comb begin
    stg_d  = {stg_q[SYNC_STAGES-2:0], din};
    prev_d = stg_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  assign level = stg_q[SYNC_STAGES-1];
  assign rise  = level & ~prev_q;

endmodule

// File: rtl/irqagg_bank.sv
// One byte-wide bank: mask register and pending latches.
module irqagg_bank #(
  parameter int                BANK_W   = 8,
  parameter logic [BANK_W-1:0] LVL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] rise,
  input  logic [BANK_W-1:0] level,
  input  logic              mask_wr,
  input  logic [BANK_W-1:0] wdata,
  input  logic              clr,
  output logic [BANK_W-1:0] status,
  output logic [BANK_W-1:0] mask
);

  localparam logic [BANK_W-1:0] EDGE_MASK = ~LVL_MASK;

  logic [BANK_W-1:0] mask_q, mask_d;
  logic [BANK_W-1:0] pend_q, pend_d;
  logic [BANK_W-1:0] capture;

  always_comb begin
    mask_d  = mask_wr ? wdata : mask_q;
    capture = rise & mask_q & EDGE_MASK;
    // a fresh capture outranks a clearing read
    pend_d  = ((pend_q & ~{BANK_W{clr}}) | capture) & EDGE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign status = (pend_q & EDGE_MASK) | (level & LVL_MASK);
  assign mask   = mask_q;

  // bank-wide clear when nothing new is captured
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (capture == '0)) |=> ((pend_q & EDGE_MASK) == '0));

  for (genvar i = 0; i < BANK_W; i++) begin : g_bit_chk
    if (EDGE_MASK[i]) begin : g_edge
      p_masked_edge_lost_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[i] && !pend_q[i]) |=> !pend_q[i]);
      p_new_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rise[i] && mask_q[i]) |=> pend_q[i]);
    end
  end

endmodule

// File: rtl/irqagg_regport.sv
// Address decode, per-bank strobes and registered read data.
module irqagg_regport
  import irqagg_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_rd,
  input  logic                        reg_wr,
  input  logic [NUM_BANKS*BANK_W-1:0] status_all,
  input  logic [NUM_BANKS*BANK_W-1:0] mask_all,
  output logic [NUM_BANKS-1:0]        mask_wr,
  output logic [NUM_BANKS-1:0]        stat_clr,
  output logic                        rd_status_any,
  output logic [BANK_W-1:0]           reg_rdata
);

  localparam int SEL_W = ADDR_W - 1;

  logic [SEL_W-1:0]  bank_sel;
  reg_kind_e         kind;
  logic [BANK_W-1:0] rd_mux;
  logic [BANK_W-1:0] rdata_q, rdata_d;

  always_comb begin
    bank_sel      = reg_addr[ADDR_W-1:1];
    kind          = reg_kind_e'(reg_addr[0]);
    mask_wr       = '0;
    stat_clr      = '0;
    rd_mux        = '0;
    rd_status_any = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == SEL_W'(b)) begin
        if (kind == KIND_MASK) begin
          rd_mux     = mask_all[b*BANK_W +: BANK_W];
          mask_wr[b] = reg_wr;
        end else begin
          rd_mux        = status_all[b*BANK_W +: BANK_W];
          stat_clr[b]   = reg_rd;
          rd_status_any = reg_rd;
        end
      end
    end
    rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  p_unmapped_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (int'(reg_addr) >= 2*NUM_BANKS)) |=> (reg_rdata == '0));
  p_one_bank_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_clr | mask_wr));

endmodule

// File: rtl/irq_edge_aggregator.sv
module irq_edge_aggregator #(
  parameter  int NUM_BANKS   = 3,
  parameter  int BANK_W      = 8,
  parameter  int LEVEL_SRC   = 12,
  parameter  int SYNC_STAGES = 2,
  localparam int NUM_SRC     = NUM_BANKS * BANK_W,
  localparam int ADDR_W      = $clog2(2 * NUM_BANKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [BANK_W-1:0]  reg_wdata,
  output logic [BANK_W-1:0]  reg_rdata,
  output logic               irq_out
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  logic [NUM_SRC-1:0]   lvl_sync, rise;
  logic [NUM_SRC-1:0]   status_all, mask_all;
  logic [NUM_BANKS-1:0] mask_wr, stat_clr;
  logic                 rd_status_any;
  logic                 out_q, out_d;
  logic                 any_unmasked;

  irqagg_sync #(.W(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_l),
    .din   (irq_req),
    .level (lvl_sync),
    .rise  (rise)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] LVL_B =
      (LEVEL_SRC / BANK_W == b) ? (BANK_W'(1) << (LEVEL_SRC % BANK_W)) : '0;
    irqagg_bank #(.BANK_W(BANK_W), .LVL_MASK(LVL_B)) u_bank (
      .clk     (clk),
      .rst_n   (rst_l),
      .rise    (rise[b*BANK_W +: BANK_W]),
      .level   (lvl_sync[b*BANK_W +: BANK_W]),
      .mask_wr (mask_wr[b]),
      .wdata   (reg_wdata),
      .clr     (stat_clr[b]),
      .status  (status_all[b*BANK_W +: BANK_W]),
      .mask    (mask_all[b*BANK_W +: BANK_W])
    );
  end

  irqagg_regport #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_port (
    .clk           (clk),
    .rst_n         (rst_l),
    .reg_addr      (reg_addr),
    .reg_rd        (reg_rd),
    .reg_wr        (reg_wr),
    .status_all    (status_all),
    .mask_all      (mask_all),
    .mask_wr       (mask_wr),
    .stat_clr      (stat_clr),
    .rd_status_any (rd_status_any),
    .reg_rdata     (reg_rdata)
  );

  always_comb begin
    any_unmasked = |(status_all & mask_all);
    out_d        = rd_status_any ? 1'b0 : any_unmasked;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign irq_out = out_q;

  p_read_drops_out_r8: assert property (@(posedge clk) disable iff (!rst_l)
    rd_status_any |=> !irq_out);
  p_out_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(irq_out) |-> $past(any_unmasked));
  p_level_live_r6: assert property (@(posedge clk) disable iff (!rst_l)
    (status_all[LEVEL_SRC] == lvl_sync[LEVEL_SRC]));

endmodule

// File: tb/irq_edge_aggregator_test.sv
module irq_edge_aggregator_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] irq_req;
  logic [2:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_edge_aggregator uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic cleanup();
    logic [7:0] d;
    irq_req = '0;
    wait_cyc(4);
    for (int a = 0; a < 6; a++) reg_write(3'(a), 8'h00);
    for (int a = 0; a < 6; a += 2) reg_read(3'(a), d);
    wait_cyc(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk8("R1 rdata after reset", reg_rdata, 8'h00);
    chk1("R1 irq_out after reset", irq_out, 1'b0);
    for (int a = 0; a < 6; a++) begin
      reg_read(3'(a), d);
      chk8("R1 register after reset", d, 8'h00);
    end
  endtask

  task automatic t_mask_rw();
    logic [7:0] d;
    reg_write(3'd1, 8'hA5);
    reg_write(3'd3, 8'h3C);
    reg_write(3'd5, 8'h0F);
    reg_write(3'd6, 8'hFF);
    reg_write(3'd7, 8'hFF);
    reg_read(3'd1, d); chk8("R2 mask bank0", d, 8'hA5);
    reg_read(3'd3, d); chk8("R2 mask bank1", d, 8'h3C);
    reg_read(3'd5, d); chk8("R2 mask bank2", d, 8'h0F);
    reg_read(3'd6, d); chk8("R2 unmapped 6", d, 8'h00);
    reg_read(3'd7, d); chk8("R2 unmapped 7", d, 8'h00);
    reg_write(3'd0, 8'hFF);
    reg_read(3'd0, d); chk8("R10 status write ignored", d, 8'h00);
    cleanup();
  endtask

  task automatic t_edge_capture();
    logic [7:0] d;
    reg_write(3'd1, 8'hFF);
    reg_write(3'd5, 8'hFF);
    irq_req[2]  = 1'b1;
    irq_req[19] = 1'b1;
    wait_cyc(4);
    chk1("R7 irq_out with pending", irq_out, 1'b1);
    reg_write(3'd0, 8'h00);
    reg_read(3'd0, d); chk8("R3 status bank0 / R10", d, 8'h04);
    reg_read(3'd4, d); chk8("R4 other bank kept", d, 8'h08);
    reg_read(3'd0, d); chk8("R4 bank0 cleared", d, 8'h00);
    reg_read(3'd4, d); chk8("R4 bank2 cleared", d, 8'h00);
    wait_cyc(2);
    chk1("R7 irq_out idle", irq_out, 1'b0);
    cleanup();
  endtask

  task automatic t_masked_lost();
    logic [7:0] d;
    irq_req[9] = 1'b1;
    wait_cyc(4);
    reg_read(3'd2, d); chk8("R5 masked edge", d, 8'h00);
    reg_write(3'd3, 8'hFF);
    wait_cyc(4);
    reg_read(3'd2, d); chk8("R5 unmask no recovery", d, 8'h00);
    chk1("R5 irq_out stays low", irq_out, 1'b0);
    irq_req[9] = 1'b0;
    wait_cyc(4);
    irq_req[9] = 1'b1;
    wait_cyc(4);
    reg_read(3'd2, d); chk8("R5 new edge after unmask", d, 8'h02);
    cleanup();
  endtask

  task automatic t_level();
    logic [7:0] d;
    irq_req[12] = 1'b1;
    wait_cyc(4);
    reg_read(3'd2, d); chk8("R6 level while masked", d, 8'h10);
    reg_write(3'd3, 8'h10);
    wait_cyc(2);
    chk1("R6 level drives irq_out", irq_out, 1'b1);
    reg_read(3'd2, d); chk8("R6 level read", d, 8'h10);
    chk1("R8 low after read", irq_out, 1'b0);
    wait_cyc(1);
    chk1("R8 rises again", irq_out, 1'b1);
    reg_read(3'd2, d); chk8("R6 not cleared", d, 8'h10);
    irq_req[12] = 1'b0;
    wait_cyc(4);
    reg_read(3'd2, d); chk8("R6 follows drop", d, 8'h00);
    wait_cyc(1);
    chk1("R6 irq_out drops", irq_out, 1'b0);
    cleanup();
  endtask

  task automatic t_mask_gate();
    logic [7:0] d;
    reg_write(3'd1, 8'h01);
    irq_req[0] = 1'b1;
    wait_cyc(4);
    chk1("R7 pending shown", irq_out, 1'b1);
    reg_write(3'd1, 8'h00);
    wait_cyc(1);
    chk1("R7 mask hides", irq_out, 1'b0);
    reg_write(3'd1, 8'h01);
    wait_cyc(1);
    chk1("R7 pending retained", irq_out, 1'b1);
    reg_read(3'd0, d); chk8("R7 status kept", d, 8'h01);
    cleanup();
  endtask

  task automatic t_rearm();
    logic [7:0] d;
    reg_write(3'd1, 8'hFF);
    reg_write(3'd3, 8'hFF);
    irq_req[1]  = 1'b1;
    irq_req[10] = 1'b1;
    wait_cyc(4);
    chk1("R8 initial high", irq_out, 1'b1);
    reg_read(3'd0, d); chk8("R8 bank0 data", d, 8'h02);
    chk1("R8 forced low", irq_out, 1'b0);
    wait_cyc(1);
    chk1("R8 fresh rise", irq_out, 1'b1);
    reg_read(3'd2, d); chk8("R8 bank1 data", d, 8'h04);
    chk1("R8 low after last read", irq_out, 1'b0);
    wait_cyc(2);
    chk1("R8 stays low", irq_out, 1'b0);
    cleanup();
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    reg_write(3'd1, 8'hFF);
    irq_req[5] = 1'b1;
    wait_cyc(2);
    reg_read(3'd0, d); chk8("R9 read before edge", d, 8'h00);
    wait_cyc(2);
    reg_read(3'd0, d); chk8("R9 edge survives clear", d, 8'h20);
    cleanup();
  endtask

  task automatic t_held();
    logic [7:0] d;
    reg_write(3'd5, 8'hFF);
    irq_req[20] = 1'b1;
    wait_cyc(4);
    reg_read(3'd4, d); chk8("R11 first capture", d, 8'h10);
    wait_cyc(6);
    reg_read(3'd4, d); chk8("R11 no recapture", d, 8'h00);
    wait_cyc(2);
    chk1("R11 irq_out low", irq_out, 1'b0);
    cleanup();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; reg_addr = '0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_mask_rw();
    t_edge_capture();
    t_masked_lost();
    t_level();
    t_mask_gate();
    t_rearm();
    t_coincide();
    t_held();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule